// File: doc/BRIEF.md
# Tone transceiver host register interface

This block sits between a microprocessor bus and the signal-processing core of a dual-tone signalling transceiver. The host uses a 4-bit data bus with a chip select, single-cycle read and write strobes, and one register-select line. With the select line low, a write loads the transmit code and a read returns the last received code. With the select line high, a write goes to the control registers and a read returns status. The tone generator, the tone decoder and the call-progress filter are outside the block. They appear as a code output with a tone-enable, a decoder strobe with a code, and a call-progress square-wave input.

Two control registers sit at one address. The first register holds the tone enable, the mode (dual-tone or call-progress) and the interrupt enable. If a write to the first register sets its steering bit, only the next control write goes to the second register, which holds the burst enable. In burst mode each transmit write runs one tone burst followed by an equal pause. Each phase lasts 51 ms in dual-tone mode and 102 ms in call-progress mode, timed by a tick input with `TICKS_PER_MS` ticks per millisecond. The interrupt output is an open-drain enable. In dual-tone mode it signals a pending event. In call-progress mode it copies the detector's square wave onto the pin.

Top module: `tone_host_regs`

## Requirements
- R1: After reset, every control bit is 0, `tone_en`, `cp_mode` and `irq_oe` are 0, and a status read returns 4'b0010. Status layout: bit0 = receive flag, bit1 = transmit ready, bit2 = interrupt pending, bit3 = 0.
- R2: A control write with wdata[3]=1 routes the single next control write to the second register, where wdata[0] is the burst enable. Control writes after that go to the first register again: bit0 tone enable, bit1 call-progress mode (driven on `cp_mode`), bit2 interrupt enable.
- R3: With burst off, `tone_en` equals control bit0, `tx_code` shows the last transmit write the cycle after it, and transmit ready stays 1.
- R4: In dual-tone mode an `rx_valid` cycle loads `rx_code`, sets the receive flag and sets interrupt pending. A data read returns the code and clears the receive flag.
- R5: In call-progress mode `rx_valid` is ignored. The receive code, the receive flag and the pending flag keep their values.
- R6: In dual-tone mode with interrupts enabled, `irq_oe` is 1 while an event is pending. A status read clears the pending flag. With interrupts disabled, `irq_oe` stays 0 but the pending flag is still set.
- R7: In call-progress mode with interrupts enabled, `irq_oe` = NOT `cp_in`, so the open-drain pin follows the detector. With interrupts disabled, `irq_oe` is 0.
- R8: In dual-tone burst mode a transmit write gives a tone of 51*TICKS_PER_MS ticks and then a pause of the same length. Transmit ready and pending are set on the tick that ends the pause.
- R9: In call-progress burst mode both the tone and the pause last 102*TICKS_PER_MS ticks.
- R10: In burst mode `tone_en` is 1 only during the tone phase and only if control bit0 is 1. With bit0 at 0 the timing still runs to completion.
- R11: The burst timer advances only on cycles with `tick` high.
- R12: A transmit write in burst mode clears transmit ready from the next cycle until the pause ends. A further write restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| rs | input | 1 | Register select: 0 data, 1 control/status |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data, 0 when not reading |
| tick | input | 1 | Timer tick enable |
| rx_valid | input | 1 | Decoder strobe: validated tone pair |
| rx_code | input | 4 | Decoded tone code |
| cp_in | input | 1 | Call-progress detector square wave |
| tx_code | output | 4 | Code for the tone generator |
| tone_en | output | 1 | Tone generator enable |
| cp_mode | output | 1 | Call-progress mode select to filters |
| irq_oe | output | 1 | Pull interrupt pin low when 1 |

## Verification
The bench steps a control write through the steering bit and checks that exactly one write goes to the second register. A design that kept steering, or never steered, would give the wrong burst length or the wrong mode. Burst tone and pause lengths are counted to the cycle in both modes. Status is read one cycle before the pause ends and again on the cycle it ends, so an off-by-one timer or a mode-blind length shows up. Tones strobed in call-progress mode must leave the receive code and flags untouched, and pausing the tick must freeze the burst. A design that decoded in that mode, or counted clocks instead of ticks, would fail those checks.

// File: rtl/tone_host_regs.sv
module tone_host_regs #(
  parameter int TICKS_PER_MS = 1000,
  parameter int BURST_MS     = 51
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       rs,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  input  logic       tick,
  input  logic       rx_valid,
  input  logic [3:0] rx_code,
  input  logic       cp_in,
  output logic [3:0] tx_code,
  output logic       tone_en,
  output logic       cp_mode,
  output logic       irq_oe
);
  localparam int LEN_DT = BURST_MS * TICKS_PER_MS;
  localparam int LEN_CP = 2 * LEN_DT;
  localparam int CW     = $clog2(LEN_CP);
  localparam logic [1:0] IDLE = 2'd0, TONE = 2'd1, PAUSE = 2'd2;

  logic [2:0]    ctl_a;
  logic          burst, sel_b;
  logic [3:0]    tx_q, rx_q;
  logic          rx_full, tx_ready, irq_pend;
  logic [1:0]    phase;
  logic [CW-1:0] cnt, last;

  wire wr_dat = cs & wr & ~rs;
  wire wr_ctl = cs & wr & rs;
  wire rd_dat = cs & rd & ~rs;
  wire rd_sts = cs & rd & rs;
  wire rx_acc = rx_valid & ~ctl_a[1];
  wire at_end = tick & (cnt >= last);
  wire done   = burst & ~wr_dat & (phase == PAUSE) & at_end;

  assign last    = ctl_a[1] ? CW'(LEN_CP - 1) : CW'(LEN_DT - 1);
  assign cp_mode = ctl_a[1];
  assign tx_code = tx_q;
  assign tone_en = ctl_a[0] & (~burst | (phase == TONE));
  assign irq_oe  = ctl_a[2] & (ctl_a[1] ? ~cp_in : irq_pend);
  assign rdata   = !(cs & rd) ? 4'd0 :
                   rs ? {1'b0, irq_pend, tx_ready, rx_full} : rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a <= '0;
      burst <= 1'b0;
      sel_b <= 1'b0;
    end else if (wr_ctl) begin
      if (sel_b) begin
        burst <= wdata[0];
        sel_b <= 1'b0;
      end else begin
        ctl_a <= wdata[2:0];
        sel_b <= wdata[3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_q     <= '0;
      rx_full  <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (wr_dat) tx_q <= wdata;
      if (rx_acc) rx_q <= rx_code;
      if (rx_acc) rx_full <= 1'b1;
      else if (rd_dat) rx_full <= 1'b0;
      if (rx_acc | done) irq_pend <= 1'b1;
      else if (rd_sts) irq_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !burst) begin
      phase    <= IDLE;
      cnt      <= '0;
      tx_ready <= 1'b1;
    end else if (wr_dat) begin
      phase    <= TONE;
      cnt      <= '0;
      tx_ready <= 1'b0;
    end else if (phase != IDLE && tick) begin
      if (at_end) begin
        cnt   <= '0;
        phase <= (phase == TONE) ? PAUSE : IDLE;
        if (phase == PAUSE) tx_ready <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module tone_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctl,
  input logic       wr_dat,
  input logic       sel_b,
  input logic       cp_mode,
  input logic       rx_valid,
  input logic [3:0] rx_code,
  input logic [3:0] rx_q,
  input logic       burst,
  input logic       tick,
  input logic [1:0] phase,
  input logic       tone_en,
  input logic       tx_ready,
  input logic       irq_pend
);
  AST_SEL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && sel_b) |=> !sel_b); // R2
  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_mode && rx_valid) |=> (rx_q == $past(rx_code))); // R4
  AST_CP_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_mode && rx_valid) |=> $stable(rx_q)); // R5
  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> ($past(rx_valid) || $past(phase) == 2'd2)); // R6
  AST_BURST_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && phase != 2'd1) |-> !tone_en); // R10
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !tick && !wr_dat && !wr_ctl) |=> $stable(phase)); // R11
  AST_BURST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && wr_dat) |=> !tx_ready); // R12
endmodule

bind tone_host_regs tone_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_dat(wr_dat), .sel_b(sel_b),
  .cp_mode(cp_mode), .rx_valid(rx_valid), .rx_code(rx_code), .rx_q(rx_q),
  .burst(burst), .tick(tick), .phase(phase), .tone_en(tone_en),
  .tx_ready(tx_ready), .irq_pend(irq_pend)
);

// File: tb/tone_host_regs_test.sv
module tone_host_regs_test;
  localparam int T  = 2;
  localparam int LD = 51 * T;
  localparam int LC = 102 * T;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0, rs = 0, tick = 1, rx_valid = 0, cp_in = 0;
  logic [3:0] wdata = 0, rx_code = 0;
  logic [3:0] rdata, tx_code;
  logic tone_en, cp_mode, irq_oe;
  int total = 0, bad = 0;
  logic [3:0] last_rx = 0;
  logic [3:0] v;

  always #2.5 clk = ~clk;

  tone_host_regs #(.TICKS_PER_MS(T)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .rs(rs),
    .wdata(wdata), .rdata(rdata), .tick(tick), .rx_valid(rx_valid),
    .rx_code(rx_code), .cp_in(cp_in), .tx_code(tx_code), .tone_en(tone_en),
    .cp_mode(cp_mode), .irq_oe(irq_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [3:0] d);
    @(negedge clk); cs = 1; wr = 1; rs = sel; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic sel, output logic [3:0] d);
    @(negedge clk); cs = 1; rd = 1; rs = sel;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic rx_pulse(input logic [3:0] c);
    @(negedge clk); rx_valid = 1; rx_code = c;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic burst_run(input int len, input string req);
    int tone_cnt = 0;
    wr_reg(0, 4'd7);
    check(tx_code == 4'd7, req, tx_code, 7);
    while (tone_en && tone_cnt < 1000) begin
      tone_cnt++;
      @(negedge clk);
    end
    check(tone_cnt == len, req, tone_cnt, len);
    repeat (len - 1) @(negedge clk);
    cs = 1; rd = 1; rs = 1;
    #1 check(rdata == 4'b0000, req, rdata, 0);
    @(negedge clk);
    #1 check(rdata == 4'b0110, req, rdata, 6);
    @(negedge clk); cs = 0; rd = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(tone_en == 0 && cp_mode == 0 && irq_oe == 0, "R1", {tone_en, cp_mode, irq_oe}, 0);
    rd_reg(1, v); check(v == 4'b0010, "R1", v, 2);

    // R3 non-burst transmit sweep
    wr_reg(1, 4'b0001);
    check(tone_en == 1, "R3", tone_en, 1);
    for (int c = 0; c < 16; c++) begin
      wr_reg(0, 4'(c));
      check(tx_code == 4'(c), "R3", tx_code, c);
    end
    rd_reg(1, v); check(v == 4'b0010, "R3", v, 2);
    wr_reg(1, 4'b0000);
    check(tone_en == 0, "R3", tone_en, 0);

    // R4 receive sweep
    for (int c = 0; c < 16; c++) begin
      rx_pulse(4'(15 - c));
      rd_reg(1, v); check(v == 4'b0111, "R4", v, 7);
      rd_reg(0, v); check(v == 4'(15 - c), "R4", v, 15 - c);
      rd_reg(1, v); check(v == 4'b0010, "R4", v, 2);
    end
    last_rx = 4'd0;

    // R6 interrupt in dual-tone mode
    wr_reg(1, 4'b0100);
    rx_pulse(4'd5); last_rx = 4'd5;
    check(irq_oe == 1, "R6", irq_oe, 1);
    rd_reg(1, v); check(v == 4'b0111, "R6", v, 7);
    check(irq_oe == 0, "R6", irq_oe, 0);
    rd_reg(0, v);
    wr_reg(1, 4'b0000);
    rx_pulse(4'd5);
    check(irq_oe == 0, "R6", irq_oe, 0);
    rd_reg(1, v); check(v == 4'b0111, "R6", v, 7);
    rd_reg(0, v);

    // R7 call-progress pass-through
    wr_reg(1, 4'b0110);
    check(cp_mode == 1, "R7", cp_mode, 1);
    for (int b = 0; b < 2; b++) begin
      cp_in = 1'(b); #1;
      check(irq_oe == !cp_in, "R7", irq_oe, !cp_in);
    end
    wr_reg(1, 4'b0010);
    for (int b = 0; b < 2; b++) begin
      cp_in = 1'(b); #1;
      check(irq_oe == 0, "R7", irq_oe, 0);
    end
    cp_in = 0;

    // R5 receive ignored in call-progress mode
    rx_pulse(4'd9);
    rd_reg(1, v); check(v == 4'b0010, "R5", v, 2);
    rd_reg(0, v); check(v == last_rx, "R5", v, last_rx);

    // R2 steering: one write to second register, then back
    wr_reg(1, 4'b1000);
    check(cp_mode == 0, "R2", cp_mode, 0);
    wr_reg(1, 4'b0011);
    check(cp_mode == 0, "R2", cp_mode, 0);
    wr_reg(1, 4'b0011);
    check(cp_mode == 1, "R2", cp_mode, 1);

    // R9 / R12 call-progress burst
    burst_run(LC, "R9");
    // R8 / R12 dual-tone burst
    wr_reg(1, 4'b0001);
    burst_run(LD, "R8");

    // R10 tone suppressed, timing still runs
    wr_reg(1, 4'b0000);
    begin
      int seen = 0;
      wr_reg(0, 4'd3);
      for (int k = 0; k < 2 * LD; k++) begin
        if (tone_en) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R10", seen, 0);
    end
    rd_reg(1, v); check(v == 4'b0110, "R10", v, 6);

    // R11 no tick, no progress
    wr_reg(1, 4'b0001);
    tick = 0;
    wr_reg(0, 4'd4);
    repeat (3 * LD) @(negedge clk);
    check(tone_en == 1, "R11", tone_en, 1);
    rd_reg(1, v); check(v == 4'b0000, "R11", v, 0);
    // R12 restart while busy
    tick = 1;
    repeat (LD / 2) @(negedge clk);
    wr_reg(0, 4'd6);
    repeat (LD - 2) @(negedge clk);
    check(tone_en == 1, "R12", tone_en, 1);
    repeat (LD + 10) @(negedge clk);
    rd_reg(1, v); check(v == 4'b0110, "R12", v, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule